// File: doc/BRIEF.md
# Transmit Attempt and Frame-Check Controller

This block sits beside the transmit engine of an Ethernet-style MAC and governs one frame at a time. When a new frame is announced it settles, from global configuration and the frame's own descriptor flags, whether a frame check sequence will be appended. It then follows the engine's attempt-start and attempt-done strobes and any collisions reported in between. After each attempt it either asks for a retransmission or closes the frame with a single completion pulse that carries success or retry error.

Two attempt policies exist. In the normal policy a frame gets up to sixteen attempts, and the block keeps a flag raised that tells the FIFO to preserve the frame's opening bytes for a resend. In the single-attempt policy one collision ends the frame, and that flag stays low. A test hook can inject a collision into every attempt, but only while the loopback mode selects internal loopback.

Top module: `tx_retry_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, every output reads 0 after that edge.
- R2: With `cfg_single_try` low, an attempt that collides and is not the 16th attempt of the frame produces a one-cycle `retx_req` in the cycle after `att_end`, with `frame_done` low.
- R3: With `cfg_single_try` low, if the 16th attempt of a frame collides, the cycle after its `att_end` shows `frame_done` and `retry_err` high and `retx_req` low.
- R4: With `cfg_single_try` high, the first attempt ends the frame: a collision gives `frame_done` with `retry_err` and no `retx_req`.
- R5: `fifo_protect` is high from the cycle after `frame_start` until the frame completes, when the single-attempt setting latched at `frame_start` is low. It is low when that setting is high and when no frame is open.
- R6: With `cfg_no_fcs` low at `frame_start`, `fcs_append` is 1 from the next cycle until the next `frame_start`.
- R7: With `cfg_no_fcs` high and `desc_padded` low, `fcs_append` equals `desc_add_fcs AND desc_eop` as sampled at `frame_start`.
- R8: With `desc_padded` high at `frame_start`, `fcs_append` is 1 whatever `cfg_no_fcs` is.
- R9: Loopback mode is `{cfg_loop, cfg_int_loop}`, with 00 normal, 01 internal, 10 external and 11 treated as normal. In mode 01 with `cfg_force_coll` high, every attempt counts as collided, so the frame ends in a retry error.
- R10: In loopback modes 00, 10 and 11, `cfg_force_coll` has no effect, and a collision-free attempt ends in success.
- R11: `coll_in` pulses while no attempt is open (between `frame_start` and `att_start`) do not count: a following clean attempt still ends in success.
- R12: Each frame produces exactly one `frame_done` pulse, accompanied by exactly one of `frame_ok` or `retry_err`. A collision-free attempt gives `frame_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_single_try | input | 1 | One attempt only, no FIFO protection |
| cfg_force_coll | input | 1 | Inject collisions in internal loopback |
| cfg_no_fcs | input | 1 | Global frame-check suppression |
| cfg_loop | input | 1 | Loopback mode, upper bit |
| cfg_int_loop | input | 1 | Loopback mode, lower bit |
| frame_start | input | 1 | Pulse opening a new frame; latches flags and config |
| desc_add_fcs | input | 1 | Descriptor requests a frame check sequence |
| desc_eop | input | 1 | Descriptor is the end-of-packet entry |
| desc_padded | input | 1 | Auto-padding added bytes to this frame |
| att_start | input | 1 | Transmit engine opens an attempt |
| att_end | input | 1 | Transmit engine closes the attempt |
| coll_in | input | 1 | Collision strobe from the engine |
| fcs_append | output | 1 | Append a frame check sequence to this frame |
| retx_req | output | 1 | Pulse requesting another attempt |
| fifo_protect | output | 1 | Keep the frame's opening bytes for resend |
| frame_done | output | 1 | Pulse closing the frame |
| frame_ok | output | 1 | Frame sent without collision, with `frame_done` |
| retry_err | output | 1 | Attempts exhausted, with `frame_done` |

## Verification
The assertions take for granted that the engine pairs each `att_start` with one later `att_end` inside an open frame, and that no `frame_start` arrives while a frame is still open. The configuration inputs are assumed steady for the whole of a frame. The stimulus keeps to this by driving each frame as a fixed sequence: announce, optional stray collision, then paired attempts until completion. It changes configuration only at a frame boundary and mixes random collision masks and settings with directed runs of sixteen collisions, forced loopback collisions and stray strobes.

// File: rtl/tx_retry_pkg.sv
package tx_retry_pkg;

    typedef enum logic [1:0] {
        LB_NORMAL   = 2'b00,
        LB_INTERNAL = 2'b01,
        LB_EXTERNAL = 2'b10,
        LB_SPARE    = 2'b11
    } lb_mode_e;

    typedef struct packed {
        logic add_fcs;
        logic eop;
        logic padded;
    } desc_flags_t;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_AGAIN,
        RES_OK,
        RES_FAIL
    } att_result_e;

    function automatic lb_mode_e decode_lb(input logic loop_b, input logic int_b);
        return lb_mode_e'({loop_b, int_b});
    endfunction

    // Padding wins, then the global setting, then the descriptor request.
    function automatic logic want_fcs(input logic no_fcs, input desc_flags_t d);
        return d.padded | ~no_fcs | (d.eop & d.add_fcs);
    endfunction

endpackage

// File: rtl/tx_loop_decode.sv
module tx_loop_decode
    import tx_retry_pkg::*;
(
    input  logic loop_b,
    input  logic int_b,
    input  logic force_req,
    output logic force_eff
);
    lb_mode_e mode;

    always_comb begin
        mode      = decode_lb(loop_b, int_b);
        force_eff = force_req && (mode == LB_INTERNAL);
    end
endmodule

// File: rtl/tx_fcs_policy.sv
module tx_fcs_policy
    import tx_retry_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic        no_fcs,
    input  desc_flags_t flags,
    output logic        fcs_append
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fcs_append <= 1'b0;
        end else if (load) begin
            fcs_append <= want_fcs(no_fcs, flags);
        end
    end
endmodule

// File: rtl/tx_attempt_seq.sv
module tx_attempt_seq
    import tx_retry_pkg::*;
#(
    parameter int MAX_TRIES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic single_req,
    input  logic force_eff,
    input  logic att_start,
    input  logic att_end,
    input  logic coll_in,
    output logic busy,
    output logic protect,
    output logic retx_req,
    output logic frame_done,
    output logic frame_ok,
    output logic retry_err
);
    localparam int CNT_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_TRIES - 1);

    logic [CNT_W-1:0] tries_q;
    logic             in_att_q;
    logic             coll_seen_q;
    logic             single_q;
    logic             force_q;
    logic             hit;
    logic             last;
    att_result_e      result;

    always_comb begin
        hit  = coll_seen_q | coll_in | force_q;
        last = single_q || (tries_q == LAST_IDX);
        if (!(busy && in_att_q && att_end)) begin
            result = RES_NONE;
        end else if (!hit) begin
            result = RES_OK;
        end else if (last) begin
            result = RES_FAIL;
        end else begin
            result = RES_AGAIN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            tries_q     <= '0;
            in_att_q    <= 1'b0;
            coll_seen_q <= 1'b0;
            single_q    <= 1'b0;
            force_q     <= 1'b0;
            retx_req    <= 1'b0;
            frame_done  <= 1'b0;
            frame_ok    <= 1'b0;
            retry_err   <= 1'b0;
        end else begin
            retx_req   <= (result == RES_AGAIN);
            frame_done <= (result == RES_OK) || (result == RES_FAIL);
            frame_ok   <= (result == RES_OK);
            retry_err  <= (result == RES_FAIL);
            if (frame_start) begin
                busy        <= 1'b1;
                tries_q     <= '0;
                in_att_q    <= 1'b0;
                coll_seen_q <= 1'b0;
                single_q    <= single_req;
                force_q     <= force_eff;
            end else if (busy) begin
                if (!in_att_q) begin
                    if (att_start) begin
                        in_att_q    <= 1'b1;
                        coll_seen_q <= 1'b0;
                    end
                end else if (att_end) begin
                    in_att_q    <= 1'b0;
                    coll_seen_q <= 1'b0;
                    if (result == RES_AGAIN) begin
                        tries_q <= tries_q + 1'b1;
                    end else begin
                        busy <= 1'b0;
                    end
                end else if (coll_in) begin
                    coll_seen_q <= 1'b1;
                end
            end
        end
    end

    assign protect = busy & ~single_q;
endmodule

// File: rtl/tx_retry_ctl.sv
module tx_retry_ctl
    import tx_retry_pkg::*;
#(
    parameter int MAX_TRIES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_single_try,
    input  logic cfg_force_coll,
    input  logic cfg_no_fcs,
    input  logic cfg_loop,
    input  logic cfg_int_loop,
    input  logic frame_start,
    input  logic desc_add_fcs,
    input  logic desc_eop,
    input  logic desc_padded,
    input  logic att_start,
    input  logic att_end,
    input  logic coll_in,
    output logic fcs_append,
    output logic retx_req,
    output logic fifo_protect,
    output logic frame_done,
    output logic frame_ok,
    output logic retry_err
);
    desc_flags_t flags;
    logic        force_eff;
    logic        busy;

    assign flags = '{add_fcs: desc_add_fcs, eop: desc_eop, padded: desc_padded};

    tx_loop_decode u_lb (
        .loop_b    (cfg_loop),
        .int_b     (cfg_int_loop),
        .force_req (cfg_force_coll),
        .force_eff (force_eff)
    );

    tx_fcs_policy u_fcs (
        .clk        (clk),
        .rst        (rst),
        .load       (frame_start),
        .no_fcs     (cfg_no_fcs),
        .flags      (flags),
        .fcs_append (fcs_append)
    );

    tx_attempt_seq #(.MAX_TRIES(MAX_TRIES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .single_req  (cfg_single_try),
        .force_eff   (force_eff),
        .att_start   (att_start),
        .att_end     (att_end),
        .coll_in     (coll_in),
        .busy        (busy),
        .protect     (fifo_protect),
        .retx_req    (retx_req),
        .frame_done  (frame_done),
        .frame_ok    (frame_ok),
        .retry_err   (retry_err)
    );
endmodule

// File: rtl/tx_retry_ctl_chk.sv
module tx_retry_ctl_chk #(
    parameter int MAX_TRIES = 16
) (
    input logic clk,
    input logic rst,
    input logic frame_start,
    input logic desc_padded,
    input logic att_end,
    input logic fcs_append,
    input logic retx_req,
    input logic fifo_protect,
    input logic frame_done,
    input logic frame_ok,
    input logic retry_err
);
    logic [7:0] retx_cnt;

    always_ff @(posedge clk) begin
        if (rst || frame_done || frame_start) begin
            retx_cnt <= '0;
        end else if (retx_req) begin
            retx_cnt <= retx_cnt + 8'd1;
        end
    end

    assert_done_one_result_R12: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (frame_ok ^ retry_err));

    assert_result_needs_done_R12: assert property (@(posedge clk) disable iff (rst)
        (frame_ok || retry_err) |-> frame_done);

    assert_retx_not_done_R2: assert property (@(posedge clk) disable iff (rst)
        retx_req |-> !frame_done);

    assert_retx_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        retx_req |-> (retx_cnt < 8'(MAX_TRIES - 1)));

    assert_err_after_all_tries_R3: assert property (@(posedge clk) disable iff (rst)
        (retry_err && retx_cnt != 8'd0) |-> (retx_cnt == 8'(MAX_TRIES - 1)));

    assert_result_follows_end_R11: assert property (@(posedge clk) disable iff (rst)
        (retx_req || frame_done) |-> $past(att_end));

    assert_protect_drops_R5: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !fifo_protect);

    assert_fcs_holds_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_start) |-> $stable(fcs_append));

    assert_pad_forces_fcs_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(frame_start && desc_padded) && !$past(rst)) |-> fcs_append);
endmodule

bind tx_retry_ctl tx_retry_ctl_chk #(.MAX_TRIES(MAX_TRIES)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .desc_padded  (desc_padded),
    .att_end      (att_end),
    .fcs_append   (fcs_append),
    .retx_req     (retx_req),
    .fifo_protect (fifo_protect),
    .frame_done   (frame_done),
    .frame_ok     (frame_ok),
    .retry_err    (retry_err)
);

// File: tb/tx_retry_ctl_tb_top.sv
module tx_retry_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TRIES      = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_single_try = 0, cfg_force_coll = 0, cfg_no_fcs = 0, cfg_loop = 0, cfg_int_loop = 0;
    logic frame_start = 0, desc_add_fcs = 0, desc_eop = 0, desc_padded = 0;
    logic att_start = 0, att_end = 0, coll_in = 0;
    logic fcs_append, retx_req, fifo_protect, frame_done, frame_ok, retry_err;

    int vectors = 0;
    int fails   = 0;
    bit ended   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_retry_ctl #(.MAX_TRIES(TRIES)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_single_try(cfg_single_try), .cfg_force_coll(cfg_force_coll),
        .cfg_no_fcs(cfg_no_fcs), .cfg_loop(cfg_loop), .cfg_int_loop(cfg_int_loop),
        .frame_start(frame_start), .desc_add_fcs(desc_add_fcs), .desc_eop(desc_eop),
        .desc_padded(desc_padded), .att_start(att_start), .att_end(att_end), .coll_in(coll_in),
        .fcs_append(fcs_append), .retx_req(retx_req), .fifo_protect(fifo_protect),
        .frame_done(frame_done), .frame_ok(frame_ok), .retry_err(retry_err)
    );

    function automatic logic exp_fcs(logic nofcs, logic af, logic ep, logic pd);
        return pd || !nofcs || (af && ep);
    endfunction

    function automatic logic exp_force(logic frc, logic lp, logic il);
        return frc && !lp && il;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic run_frame(input logic sgl, input logic frc, input logic nofcs,
                             input logic lp, input logic il, input logic af,
                             input logic ep, input logic pd,
                             input logic [15:0] mask, input logic stray);
        logic fe;
        int   maxa;
        logic hit;
        logic stop;
        string tag;
        fe   = exp_force(frc, lp, il);
        maxa = sgl ? 1 : TRIES;
        tag  = fe ? "R9" : (frc ? "R10" : (sgl ? "R4" : "R3"));
        @(negedge clk);
        cfg_single_try = sgl; cfg_force_coll = frc; cfg_no_fcs = nofcs;
        cfg_loop = lp; cfg_int_loop = il;
        desc_add_fcs = af; desc_eop = ep; desc_padded = pd;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        desc_add_fcs = $urandom_range(0, 1); desc_eop = $urandom_range(0, 1);
        desc_padded = $urandom_range(0, 1);
        chk(pd ? "R8" : (nofcs ? "R7" : "R6"), "fcs_append", fcs_append, exp_fcs(nofcs, af, ep, pd));
        chk("R5", "fifo_protect open", fifo_protect, !sgl);
        if (stray) begin
            coll_in = 1'b1;
            @(negedge clk);
            coll_in = 1'b0;
            chk("R11", "done after stray", frame_done, 1'b0);
        end
        stop = 1'b0;
        for (int i = 0; i < TRIES && !stop; i++) begin
            @(negedge clk); att_start = 1'b1;
            @(negedge clk); att_start = 1'b0; coll_in = mask[i];
            @(negedge clk); coll_in = 1'b0; att_end = 1'b1;
            @(negedge clk); att_end = 1'b0;
            hit = mask[i] || fe;
            if (hit && (i + 1 < maxa)) begin
                chk("R2", "retx_req", retx_req, 1'b1);
                chk("R2", "frame_done", frame_done, 1'b0);
            end else begin
                stop = 1'b1;
                chk("R12", "frame_done", frame_done, 1'b1);
                chk(hit ? tag : (stray ? "R11" : (frc ? "R10" : "R12")), "retry_err", retry_err, hit);
                chk("R12", "frame_ok", frame_ok, !hit);
                chk("R4", "retx_req at end", retx_req, 1'b0);
            end
        end
        @(negedge clk);
        chk("R12", "done single pulse", frame_done, 1'b0);
        chk("R5", "fifo_protect idle", fifo_protect, 1'b0);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset with busy-looking inputs
        frame_start = 1'b1; att_start = 1'b1; att_end = 1'b1; coll_in = 1'b1; desc_padded = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "fcs_append", fcs_append, 1'b0);
        chk("R1", "retx_req", retx_req, 1'b0);
        chk("R1", "fifo_protect", fifo_protect, 1'b0);
        chk("R1", "frame_done", frame_done, 1'b0);
        chk("R1", "frame_ok", frame_ok, 1'b0);
        chk("R1", "retry_err", retry_err, 1'b0);
        frame_start = 0; att_start = 0; att_end = 0; coll_in = 0; desc_padded = 0;
        @(negedge clk);
        rst = 1'b0;

        // Directed corners
        run_frame(0, 0, 0, 0, 0, 0, 0, 0, 16'hFFFF, 0);   // R3: sixteen collisions
        run_frame(0, 0, 0, 0, 0, 0, 0, 0, 16'h7FFF, 0);   // R2: success on the last try
        run_frame(1, 0, 1, 0, 0, 1, 1, 0, 16'h0001, 0);   // R4 single, R7
        run_frame(1, 0, 1, 0, 0, 1, 0, 0, 16'h0000, 0);   // R4 clean, R7 no eop
        run_frame(0, 0, 1, 0, 0, 0, 0, 1, 16'h0000, 0);   // R8
        run_frame(0, 1, 0, 0, 1, 0, 0, 0, 16'h0000, 0);   // R9
        run_frame(1, 1, 0, 0, 1, 0, 0, 0, 16'h0000, 0);   // R9 single
        run_frame(0, 1, 0, 0, 0, 0, 0, 0, 16'h0000, 0);   // R10 mode 00
        run_frame(0, 1, 0, 1, 0, 0, 0, 0, 16'h0000, 0);   // R10 mode 10
        run_frame(0, 1, 0, 1, 1, 0, 0, 0, 16'h0000, 0);   // R10 mode 11
        run_frame(0, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 1);   // R11 stray
        run_frame(1, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 1);   // R11 stray, single

        // Constrained random frames
        for (int n = 0; n < 300; n++) begin
            logic [15:0] m;
            m = '0;
            for (int b = 0; b < 16; b++) m[b] = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 9) == 0) m = 16'hFFFF;
            run_frame($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
                      $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                      $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3) == 0,
                      m, $urandom_range(0, 3) == 0);
        end
        finish_run();
    end
endmodule